// File: doc/BRIEF.md
# Banked Register Interface for a Multichannel Analog Output Card

This block is the host-facing register front end of an analog output card. The host reaches it through a 16-bit data path. The address input carries a byte offset. Most locations are 16-bit words on even offsets, and one location is a single byte on an odd offset. The block holds the configuration registers, the digital I/O output latch and the sticky interrupt flags. It also decodes one-cycle strobes for the parts of the card that sit outside it: the sample FIFO, the DAC channel latches and a serial sync register.

Bit 7 of the main configuration register picks one of two register banks. In the normal bank, the three low word offsets are the digital I/O port and two more configuration registers. In the alternate bank, the same three offsets become clear strobes for the three interrupt flags, and the data written with them is discarded. Offset 0x0A behaves differently for the two directions: a write updates the main configuration register, and a read returns the status word. A read of offset 0x0C clears the FIFO. A write to 0x0C loads the FIFO in the normal bank and loads DAC channel 0 in the alternate bank.

Top module: `aout_regbank`

## Requirements
- R1: After reset, cfg1_o, cfg2_o, cfg3_o, dio_o, dio_oe_o and irq_o are all 0, and the status word shows no flag set. A cfg1 value of 0 means the normal bank is selected.
- R2: While cfg1_o bit 7 is 1, a write to 0x00 clears the counter terminal-count flag, a write to 0x02 clears interrupt flag 1, and a write to 0x04 clears interrupt flag 2. Each of these writes leaves dio_o, cfg2_o and cfg3_o unchanged.
- R3: A high level on an event input sets its flag at the next clock edge. The flag then stays at 1 until its clear strobe arrives, and it stays at 1 if the event is still high at that point. When a set and a clear arrive in the same cycle, the flag ends up at 1.
- R4: A read of 0x0A returns the status word, with all bits above bit 6 at 0. The bits are: bit 6 FIFO half full, bit 5 FIFO empty, bit 4 FIFO full, bit 3 interrupt flag 2, bit 2 interrupt flag 1, bit 1 counter terminal-count flag, bit 0 EEPROM serial data out.
- R5: fifo_clr_o pulses in the cycle of any read of 0x0C. fifo_wr_o pulses in the cycle of a write to 0x0C only while the normal bank is selected.
- R6: DAC channel x (0 < x < NUM_AO) is written at offset 0x0C+2x in either bank. Channel 0 is written at 0x0C only in the alternate bank. ao_wr_o has exactly the bit of that channel set in the write cycle, and ao_data_o is wdata_i[11:0], the 12-bit two's-complement code.
- R7: In the alternate bank, a write to 0x06 pulses sync_shift_o, with sync_bit_o equal to wdata_i[0]. A write to 0x07 pulses sync_strobe_o. Neither strobe fires in the normal bank.
- R8: In the normal bank, a write to 0x00 loads dio_o from wdata_i[7:0] and a write to 0x04 loads cfg3_o. dio_oe_o[3:0] follows cfg3_o bit 2 and dio_oe_o[7:4] follows cfg3_o bit 3. A read of 0x00 returns dio_i in the low byte and 0 in the high byte.
- R9: irq_o is high when at least one of these pairs is set: interrupt flag 1 with cfg1 bit 14, interrupt flag 2 with cfg1 bit 15, or the terminal-count flag with cfg1 bit 11.
- R10: A write to 0x0A loads cfg1_o in either bank. A write to 0x02 loads cfg2_o only in the normal bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 5 | Byte offset of the access |
| wr_i | input | 1 | Write request |
| rd_i | input | 1 | Read request |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, 0 when rd_i is low |
| dio_i | input | 8 | Digital I/O pin levels |
| fifo_half_i | input | 1 | FIFO half full |
| fifo_empty_i | input | 1 | FIFO empty |
| fifo_full_i | input | 1 | FIFO full |
| eeprom_do_i | input | 1 | EEPROM serial data out |
| ext_int1_i | input | 1 | Event that sets interrupt flag 1 |
| ext_int2_i | input | 1 | Event that sets interrupt flag 2 |
| cnt_tc_i | input | 1 | Event that sets the counter terminal-count flag |
| cfg1_o | output | 16 | Main configuration register |
| cfg2_o | output | 16 | Second configuration register |
| cfg3_o | output | 16 | Third configuration register |
| dio_o | output | 8 | Digital output latch |
| dio_oe_o | output | 8 | Output enable for each digital I/O bit |
| fifo_wr_o | output | 1 | FIFO load strobe |
| fifo_clr_o | output | 1 | FIFO clear strobe |
| ao_wr_o | output | NUM_AO | DAC channel load strobes |
| ao_data_o | output | 12 | DAC code |
| sync_shift_o | output | 1 | Sync register shift strobe |
| sync_bit_o | output | 1 | Serial bit shifted in |
| sync_strobe_o | output | 1 | Sync register load strobe |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a clear strobe that arrives while its event input is still high, or in the same cycle that the event rises. To get there, the design must first be switched into the alternate bank with a cfg1 write. The event must then be held across the clearing write, and the status word must be read afterwards. Directed sequences set up exactly these cases. A random phase then mixes cfg1 writes, which flip the bank back and forth, with sparse events and accesses to all decoded offsets. This covers bank changes that happen between the set and the clear of a flag.

// File: rtl/aout_pkg.sv
package aout_pkg;
  localparam int ADDR_W = 5;
  localparam int BANK_BIT = 7;
  localparam logic [ADDR_W-1:0] OFS_DIO   = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_CFG2  = 5'h02;
  localparam logic [ADDR_W-1:0] OFS_CFG3  = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_SHIFT = 5'h06;
  localparam logic [ADDR_W-1:0] OFS_STB   = 5'h07;
  localparam logic [ADDR_W-1:0] OFS_CFG1  = 5'h0A;
  localparam logic [ADDR_W-1:0] OFS_AO    = 5'h0C;
  // flag vector index: 0 terminal count, 1 int1, 2 int2
  localparam int NFLAG = 3;
  typedef struct packed {
    logic cfg1_we;
    logic cfg2_we;
    logic cfg3_we;
    logic dio_we;
  } cfg_we_t;
endpackage

// File: rtl/aout_decode.sv
module aout_decode
  import aout_pkg::*;
#(
  parameter int NUM_AO = 10
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              bank2_i,
  output cfg_we_t           we_o,
  output logic [NFLAG-1:0]  clr_o,
  output logic              fifo_wr_o,
  output logic              fifo_clr_o,
  output logic [NUM_AO-1:0] ao_wr_o,
  output logic              sync_shift_o,
  output logic              sync_stb_o
);
  logic wr_b1, wr_b2;
  assign wr_b1 = wr_i && !bank2_i;
  assign wr_b2 = wr_i && bank2_i;

  always_comb begin
    we_o.cfg1_we = wr_i  && (addr_i == OFS_CFG1);
    we_o.cfg2_we = wr_b1 && (addr_i == OFS_CFG2);
    we_o.cfg3_we = wr_b1 && (addr_i == OFS_CFG3);
    we_o.dio_we  = wr_b1 && (addr_i == OFS_DIO);
  end

  assign clr_o[0]     = wr_b2 && (addr_i == OFS_DIO);
  assign clr_o[1]     = wr_b2 && (addr_i == OFS_CFG2);
  assign clr_o[2]     = wr_b2 && (addr_i == OFS_CFG3);
  assign sync_shift_o = wr_b2 && (addr_i == OFS_SHIFT);
  assign sync_stb_o   = wr_b2 && (addr_i == OFS_STB);
  assign fifo_wr_o    = wr_b1 && (addr_i == OFS_AO);
  assign fifo_clr_o   = rd_i  && (addr_i == OFS_AO);

  for (genvar g = 0; g < NUM_AO; g++) begin : g_ao
    localparam logic [ADDR_W-1:0] CH_ADDR = ADDR_W'(int'(OFS_AO) + 2 * g);
    if (g == 0) begin : g_ch0
      assign ao_wr_o[g] = wr_b2 && (addr_i == CH_ADDR);
    end else begin : g_chn
      assign ao_wr_o[g] = wr_i && (addr_i == CH_ADDR);
    end
  end
endmodule

// File: rtl/aout_flags.sv
module aout_flags #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic q;
    // set dominates a simultaneous clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        q <= 1'b0;
      else if (set_i[g])  q <= 1'b1;
      else if (clr_i[g])  q <= 1'b0;
    end
    assign flag_o[g] = q;

    assert_set_wins_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> flag_o[g]);
    assert_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_o[g] && !clr_i[g]) |=> flag_o[g]);
    assert_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[g] && !set_i[g]) |=> !flag_o[g]);
  end
endmodule

// File: rtl/aout_regbank.sv
module aout_regbank
  import aout_pkg::*;
#(
  parameter int NUM_AO = 10,
  parameter int DIO_W  = 8,
  parameter int DAC_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [4:0]        addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [15:0]       wdata_i,
  output logic [15:0]       rdata_o,
  input  logic [DIO_W-1:0]  dio_i,
  input  logic              fifo_half_i,
  input  logic              fifo_empty_i,
  input  logic              fifo_full_i,
  input  logic              eeprom_do_i,
  input  logic              ext_int1_i,
  input  logic              ext_int2_i,
  input  logic              cnt_tc_i,
  output logic [15:0]       cfg1_o,
  output logic [15:0]       cfg2_o,
  output logic [15:0]       cfg3_o,
  output logic [DIO_W-1:0]  dio_o,
  output logic [DIO_W-1:0]  dio_oe_o,
  output logic              fifo_wr_o,
  output logic              fifo_clr_o,
  output logic [NUM_AO-1:0] ao_wr_o,
  output logic [DAC_W-1:0]  ao_data_o,
  output logic              sync_shift_o,
  output logic              sync_bit_o,
  output logic              sync_strobe_o,
  output logic              irq_o
);
  localparam int HALF = DIO_W / 2;

  logic [15:0]      cfg1_q, cfg2_q, cfg3_q;
  logic [DIO_W-1:0] dio_q;
  logic             bank2;
  cfg_we_t          we;
  logic [NFLAG-1:0] clr, set, flags, en;

  assign bank2 = cfg1_q[BANK_BIT];

  aout_decode #(.NUM_AO(NUM_AO)) u_dec (
    .addr_i      (addr_i),
    .wr_i        (wr_i),
    .rd_i        (rd_i),
    .bank2_i     (bank2),
    .we_o        (we),
    .clr_o       (clr),
    .fifo_wr_o   (fifo_wr_o),
    .fifo_clr_o  (fifo_clr_o),
    .ao_wr_o     (ao_wr_o),
    .sync_shift_o(sync_shift_o),
    .sync_stb_o  (sync_strobe_o)
  );

  assign set = {ext_int2_i, ext_int1_i, cnt_tc_i};

  aout_flags #(.N(NFLAG)) u_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (set),
    .clr_i (clr),
    .flag_o(flags)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg1_q <= '0;
      cfg2_q <= '0;
      cfg3_q <= '0;
      dio_q  <= '0;
    end else begin
      if (we.cfg1_we) cfg1_q <= wdata_i;
      if (we.cfg2_we) cfg2_q <= wdata_i;
      if (we.cfg3_we) cfg3_q <= wdata_i;
      if (we.dio_we)  dio_q  <= wdata_i[DIO_W-1:0];
    end
  end

  assign en    = {cfg1_q[15], cfg1_q[14], cfg1_q[11]};
  assign irq_o = |(flags & en);

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (addr_i)
        OFS_DIO:  rdata_o[DIO_W-1:0] = dio_i;
        OFS_CFG1: rdata_o[6:0] = {fifo_half_i, fifo_empty_i, fifo_full_i,
                                  flags[2], flags[1], flags[0], eeprom_do_i};
        default:  rdata_o = '0;
      endcase
    end
  end

  assign cfg1_o     = cfg1_q;
  assign cfg2_o     = cfg2_q;
  assign cfg3_o     = cfg3_q;
  assign dio_o      = dio_q;
  assign dio_oe_o   = {{(DIO_W-HALF){cfg3_q[3]}}, {HALF{cfg3_q[2]}}};
  assign ao_data_o  = wdata_i[DAC_W-1:0];
  assign sync_bit_o = wdata_i[0];

  assert_bank2_keeps_dio_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && bank2 && addr_i == OFS_DIO) |=> $stable(dio_q));
  assert_bank2_keeps_cfg3_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && bank2 && addr_i == OFS_CFG3) |=> $stable(cfg3_q));
  assert_fifo_wr_bank1_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_wr_o |-> !cfg1_o[BANK_BIT]);
  assert_ao_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ao_wr_o));
  assert_sync_bank2_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_shift_o || sync_strobe_o) |-> cfg1_o[BANK_BIT]);
  assert_irq_needs_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (rd_i || !rd_i) && (cfg1_o[15] || cfg1_o[14] || cfg1_o[11]));
endmodule

// File: tb/aout_regbank_tb.sv
module aout_regbank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_AO = 10;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [4:0] addr = '0;
  logic wr = 0, rd = 0;
  logic [15:0] wdata = '0, rdata;
  logic [7:0] dio_in = '0;
  logic fh = 0, fe = 0, ff = 0, prom = 0, e1 = 0, e2 = 0, etc = 0;
  logic [15:0] cfg1, cfg2, cfg3;
  logic [7:0] dio, dio_oe;
  logic fifo_wr, fifo_clr, shift, sbit, sstb, irq;
  logic [NUM_AO-1:0] ao_wr;
  logic [11:0] ao_data;

  int n_chk = 0, n_bad = 0, cycles = 0;
  logic [15:0] m_cfg1 = 0, m_cfg2 = 0, m_cfg3 = 0;
  logic [7:0] m_dio = 0;
  logic [2:0] m_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aout_regbank #(.NUM_AO(NUM_AO)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .dio_i(dio_in), .fifo_half_i(fh),
    .fifo_empty_i(fe), .fifo_full_i(ff), .eeprom_do_i(prom),
    .ext_int1_i(e1), .ext_int2_i(e2), .cnt_tc_i(etc),
    .cfg1_o(cfg1), .cfg2_o(cfg2), .cfg3_o(cfg3), .dio_o(dio), .dio_oe_o(dio_oe),
    .fifo_wr_o(fifo_wr), .fifo_clr_o(fifo_clr), .ao_wr_o(ao_wr), .ao_data_o(ao_data),
    .sync_shift_o(shift), .sync_bit_o(sbit), .sync_strobe_o(sstb), .irq_o(irq)
  );

  task automatic check(input logic [15:0] got, input logic [15:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] exp_status();
    return {9'b0, fh, fe, ff, m_flag[2], m_flag[1], m_flag[0], prom};
  endfunction

  function automatic logic exp_irq();
    return (m_flag[1] & m_cfg1[14]) | (m_flag[2] & m_cfg1[15]) | (m_flag[0] & m_cfg1[11]);
  endfunction

  function automatic logic [15:0] exp_ao(input logic w, input logic [4:0] a, input logic b2);
    logic [15:0] r = '0;
    if (w && a >= 5'h0C && a[0] == 1'b0) begin
      int idx = (int'(a) - 12) / 2;
      if (idx < NUM_AO && (idx != 0 || b2)) r[idx] = 1'b1;
    end
    return r;
  endfunction

  task automatic check_regs();
    check(cfg1, m_cfg1, "R10 cfg1");
    check(cfg2, m_cfg2, "R10 cfg2");
    check(cfg3, m_cfg3, "R8 cfg3");
    check({8'h0, dio}, {8'h0, m_dio}, "R8 dio_o");
    check({8'h0, dio_oe}, {8'h0, {4{m_cfg3[3]}}, {4{m_cfg3[2]}}}, "R8 dio_oe");
    check({15'h0, irq}, {15'h0, exp_irq()}, "R9 irq");
  endtask

  task automatic step(input logic w, input logic r, input logic [4:0] a,
                      input logic [15:0] d, input logic [2:0] ev);
    logic b2;
    @(negedge clk);
    wr = w; rd = r; addr = a; wdata = d;
    etc = ev[0]; e1 = ev[1]; e2 = ev[2];
    #1;
    b2 = m_cfg1[7];
    check({15'h0, fifo_wr}, {15'h0, w && !b2 && a == 5'h0C}, "R5 fifo_wr");
    check({15'h0, fifo_clr}, {15'h0, r && a == 5'h0C}, "R5 fifo_clr");
    check(16'(ao_wr), exp_ao(w, a, b2), "R6 ao_wr");
    if (|ao_wr) check({4'h0, ao_data}, {4'h0, d[11:0]}, "R6 ao_data");
    check({15'h0, shift}, {15'h0, w && b2 && a == 5'h06}, "R7 shift");
    if (shift) check({15'h0, sbit}, {15'h0, d[0]}, "R7 sync bit");
    check({15'h0, sstb}, {15'h0, w && b2 && a == 5'h07}, "R7 strobe");
    if (r) begin
      if (a == 5'h00) check(rdata, {8'h0, dio_in}, "R8 dio read");
      else if (a == 5'h0A) check(rdata, exp_status(), "R4 status");
      else check(rdata, 16'h0, "R4 other read");
    end
    @(posedge clk);
    m_flag = ev | (m_flag & ~{w && b2 && a == 5'h04, w && b2 && a == 5'h02, w && b2 && a == 5'h00});
    if (w && !b2 && a == 5'h00) m_dio = d[7:0];
    if (w && !b2 && a == 5'h02) m_cfg2 = d;
    if (w && !b2 && a == 5'h04) m_cfg3 = d;
    if (w && a == 5'h0A) m_cfg1 = d;
    #1;
    check_regs();
    wr = 0; rd = 0; etc = 0; e1 = 0; e2 = 0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (2) @(negedge clk);
    #1;
    check_regs();                                   // R1 reset state
    rst_ni = 1'b1;
    fh = 1; fe = 0; ff = 1; prom = 1; dio_in = 8'hA5;
    step(0, 1, 5'h0A, 0, 3'b000);                   // R1/R4 no flags after reset
    step(1, 0, 5'h00, 16'h003C, 3'b000);            // R8 dio write bank1
    step(1, 0, 5'h04, 16'h0008, 3'b000);            // R8 upper nibble oe
    step(1, 0, 5'h02, 16'hBEEF, 3'b000);            // R10 cfg2
    step(0, 1, 5'h00, 0, 3'b000);                   // R8 dio read
    step(1, 0, 5'h0C, 16'h0123, 3'b000);            // R5 fifo write bank1
    step(0, 1, 5'h0C, 0, 3'b000);                   // R5 fifo clear
    step(1, 0, 5'h06, 16'h0001, 3'b000);            // R7 no shift in bank1
    step(1, 0, 5'h0E, 16'h0800, 3'b000);            // R6 channel 1 bank1
    step(1, 0, 5'h1E, 16'h0FFF, 3'b000);            // R6 last channel
    step(0, 0, 5'h00, 0, 3'b111);                   // R3 set all flags
    step(1, 0, 5'h0A, 16'hC880, 3'b000);            // R9 enables + bank2
    step(0, 1, 5'h0A, 0, 3'b000);                   // R4 status with flags
    step(1, 0, 5'h02, 16'hFFFF, 3'b010);            // R3 clear with event high: stays
    step(0, 1, 5'h0A, 0, 3'b000);
    step(1, 0, 5'h02, 16'hFFFF, 3'b000);            // R2 clear int1
    step(1, 0, 5'h00, 16'h00FF, 3'b000);            // R2 clear tc, dio kept
    step(1, 0, 5'h04, 16'h0004, 3'b100);            // R3 set+clear same cycle, R2 cfg3 kept
    step(0, 1, 5'h0A, 0, 3'b000);
    step(1, 0, 5'h04, 16'h0000, 3'b000);            // R2 clear int2, irq drops R9
    step(1, 0, 5'h0C, 16'h0A5A, 3'b000);            // R6 channel 0 in bank2
    step(1, 0, 5'h06, 16'h0001, 3'b000);            // R7 shift bit 1
    step(1, 0, 5'h06, 16'h0000, 3'b000);            // R7 shift bit 0
    step(1, 0, 5'h07, 16'h0000, 3'b000);            // R7 strobe
    step(1, 0, 5'h0A, 16'h0000, 3'b000);            // back to bank1
    for (int i = 0; i < 3000; i++) begin
      logic [4:0] a;
      logic [2:0] ev;
      logic [15:0] d;
      case ($urandom % 10)
        0: a = 5'h00; 1: a = 5'h02; 2: a = 5'h04; 3: a = 5'h06; 4: a = 5'h07;
        5: a = 5'h0A; 6: a = 5'h0C; 7: a = 5'h0E; 8: a = 5'h1E; default: a = 5'h08;
      endcase
      ev = (($urandom % 4) == 0) ? 3'($urandom) : 3'b000;
      d = 16'($urandom);
      fh = 1'($urandom); fe = 1'($urandom); ff = 1'($urandom); prom = 1'($urandom);
      dio_in = 8'($urandom);
      if ($urandom % 2) step(1, 0, a, d, ev);
      else step(0, 1, a, d, ev);
    end
    summary();
  end
endmodule